// File: doc/BRIEF.md
# Translation Buffer With Test-Register Access

This block is a small set-associative translation buffer that is reached only through a pair of test registers, not through a page walker. The command side carries an operation bit, a linear page address, a valid bit and three attribute selectors. The selectors cover the dirty, user and writable attributes, and each one is a true bit paired with a complemented bit. The data side carries a physical page address, a way number and a control bit. Each operation either installs one entry or searches the indexed set. After a search, the block returns a hit flag, the physical address, the way and the stored attributes of the single matching entry.

The low bits of the linear address select one of `SETS` sets, and the remaining bits form the tag. An install goes either to the way named on the data side or to the way chosen by an internal round-robin pointer. A search counts as a hit only when exactly one entry in the set qualifies. One search or install can start per clock, and its response is registered one cycle later.

Top module: `tlb_testport`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `rsp_valid`, `rsp_hit`, `rsp_phys`, `rsp_way` and `rsp_attr` are zero. All entries are invalid, so any search made before the next install misses, and the way pointer restarts at way 0.
- R2: An operation with `op_valid`=1 and `op_lookup`=0 is an install. It writes set `op_lin[IDX_W-1:0]` with tag `op_lin[LIN_W-1:IDX_W]`, physical address `dat_phys` and entry valid bit `op_v`.
- R3: An operation with `op_valid`=1 and `op_lookup`=1 is a search. In the next cycle `rsp_valid` is 1 and `rsp_hit` is 1 only when exactly one entry in the indexed set qualifies. An entry qualifies when it is valid, its tag is equal, and all three of its attributes satisfy their selectors. `rsp_hit` is never 1 while `rsp_valid` is 0.
- R4: `op_attr` holds three selector pairs: bits [1:0] for dirty, [3:2] for user and [5:4] for writable. In each pair the upper bit is the true bit and the lower bit is the complement. On a search, 2'b10 accepts only attribute 1, 2'b01 accepts only attribute 0, 2'b11 accepts either value, and 2'b00 accepts nothing.
- R5: On an install, selector 2'b10 stores the attribute as 1 and 2'b01 stores it as 0. The other two codes leave the stored value undefined.
- R6: An install with `dat_ctl`=1 writes way `dat_way` and does not move the way pointer.
- R7: An install with `dat_ctl`=0 writes the way named by the pointer. The pointer then advances by one and wraps from way `WAYS`-1 back to 0.
- R8: On a hit, `rsp_phys`, `rsp_way` and `rsp_attr` take the matching entry's physical address, its way number and its stored attributes, packed as {writable, user, dirty}.
- R9: On a miss, including a search where two or more entries qualify, `rsp_hit` is 0 and `rsp_phys`, `rsp_way` and `rsp_attr` keep their previous values.
- R10: An install with `op_v`=0 invalidates the addressed way, so that entry no longer qualifies for any search.
- R11: The cycle after an install, or after a cycle with no operation, `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Start an operation this cycle |
| op_lookup | input | 1 | Operation bit: 0 install, 1 search |
| op_lin | input | LIN_W | Linear page address (set index and tag) |
| op_v | input | 1 | Valid bit written on install |
| op_attr | input | 6 | Three true/complement attribute selector pairs |
| dat_phys | input | PHYS_W | Physical page address to install |
| dat_way | input | WAY_W | Way number used when `dat_ctl` is 1 |
| dat_ctl | input | 1 | Install control: 1 uses `dat_way`, 0 uses the pointer |
| rsp_valid | output | 1 | Search response present |
| rsp_hit | output | 1 | Exactly one entry qualified |
| rsp_phys | output | PHYS_W | Physical address of the hit entry |
| rsp_way | output | WAY_W | Way number of the hit entry |
| rsp_attr | output | 3 | Stored {writable, user, dirty} of the hit entry |

## Verification
Two things can happen on the same clock edge: an install updating a way's storage, and a search reading that same set. This arises whenever a search follows an install with no gap. The bench drives its vector table back to back, so each search examines the set that the preceding edge has just written. It covers the duplicate-tag case, where a pointer-driven install creates a second qualifying entry; that search must report a miss and keep the earlier response. It also covers a directed install that clears one of the duplicates, after which the immediately following search must hit the survivor with the survivor's data.

// File: rtl/tlb_tp_pkg.sv
package tlb_tp_pkg;

  // attributes per entry: index 0 dirty, 1 user, 2 writable
  localparam int N_ATTR = 3;

  // search qualifier for one true/complement selector pair
  function automatic logic sel_accepts(input logic [1:0] sel, input logic stored);
    case (sel)
      2'b11:   sel_accepts = 1'b1;
      2'b10:   sel_accepts = stored;
      2'b01:   sel_accepts = ~stored;
      default: sel_accepts = 1'b0;
    endcase
  endfunction

  // value written for one selector pair; undefined codes become 0
  function automatic logic sel_store(input logic [1:0] sel);
    sel_store = (sel == 2'b10);
  endfunction

endpackage

// File: rtl/tlb_way_store.sv
module tlb_way_store #(
  parameter int SETS   = 8,
  parameter int DATA_W = 40,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wvalid,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  // payload array without reset so it maps to distributed RAM
  logic [DATA_W-1:0] mem [SETS];
  logic [SETS-1:0]   vld;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     vld <= '0;
    else if (we) vld[waddr] <= wvalid;
  end

  assign rdata  = mem[raddr];
  assign rvalid = vld[raddr];

endmodule

// File: rtl/tlb_attr_match.sv
module tlb_attr_match
  import tlb_tp_pkg::*;
#(
  parameter int TAG_W = 17
) (
  input  logic                ent_valid,
  input  logic [TAG_W-1:0]    ent_tag,
  input  logic [N_ATTR-1:0]   ent_attr,
  input  logic [TAG_W-1:0]    q_tag,
  input  logic [2*N_ATTR-1:0] q_sel,
  output logic                qualifies
);

  logic [N_ATTR-1:0] attr_ok;

  for (genvar a = 0; a < N_ATTR; a++) begin : g_attr
    assign attr_ok[a] = sel_accepts(q_sel[2*a+1 -: 2], ent_attr[a]);
  end

  assign qualifies = ent_valid && (ent_tag == q_tag) && (&attr_ok);

endmodule

// File: rtl/tlb_way_ptr.sv
module tlb_way_ptr #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [WAY_W-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (step)
      ptr <= (ptr == WAY_W'(WAYS - 1)) ? '0 : ptr + 1'b1;
  end

endmodule

// File: rtl/tlb_testport.sv
module tlb_testport
  import tlb_tp_pkg::*;
#(
  parameter int LIN_W  = 20,
  parameter int PHYS_W = 20,
  parameter int SETS   = 8,
  parameter int WAYS   = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_valid,
  input  logic                op_lookup,
  input  logic [LIN_W-1:0]    op_lin,
  input  logic                op_v,
  input  logic [2*N_ATTR-1:0] op_attr,
  input  logic [PHYS_W-1:0]   dat_phys,
  input  logic [WAY_W-1:0]    dat_way,
  input  logic                dat_ctl,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [PHYS_W-1:0]   rsp_phys,
  output logic [WAY_W-1:0]    rsp_way,
  output logic [N_ATTR-1:0]   rsp_attr
);

  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = LIN_W - IDX_W;
  localparam int DATA_W = TAG_W + PHYS_W + N_ATTR;
  localparam int CNT_W  = $clog2(WAYS + 1);

  logic [IDX_W-1:0]  set_idx;
  logic [TAG_W-1:0]  q_tag;
  logic              wr_fire, lk_fire;
  logic [WAY_W-1:0]  ptr_q, wsel;
  logic [N_ATTR-1:0] new_attr;
  logic [DATA_W-1:0] wdata;

  assign set_idx = op_lin[IDX_W-1:0];
  assign q_tag   = op_lin[LIN_W-1:IDX_W];
  assign wr_fire = op_valid && !op_lookup;
  assign lk_fire = op_valid && op_lookup;
  assign wsel    = dat_ctl ? dat_way : ptr_q;

  for (genvar a = 0; a < N_ATTR; a++) begin : g_newattr
    assign new_attr[a] = sel_store(op_attr[2*a+1 -: 2]);
  end

  assign wdata = {q_tag, dat_phys, new_attr};

  tlb_way_ptr #(.WAYS(WAYS)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .step (wr_fire && !dat_ctl),
    .ptr  (ptr_q)
  );

  logic [WAYS-1:0]   way_hit;
  logic [PHYS_W-1:0] way_phys [WAYS];
  logic [N_ATTR-1:0] way_attr [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DATA_W-1:0] rd;
    logic              rv;

    tlb_way_store #(.SETS(SETS), .DATA_W(DATA_W)) u_store (
      .clk    (clk),
      .rst    (rst),
      .we     (wr_fire && (wsel == WAY_W'(w))),
      .waddr  (set_idx),
      .wdata  (wdata),
      .wvalid (op_v),
      .raddr  (set_idx),
      .rdata  (rd),
      .rvalid (rv)
    );

    tlb_attr_match #(.TAG_W(TAG_W)) u_match (
      .ent_valid (rv),
      .ent_tag   (rd[DATA_W-1 -: TAG_W]),
      .ent_attr  (rd[N_ATTR-1:0]),
      .q_tag     (q_tag),
      .q_sel     (op_attr),
      .qualifies (way_hit[w])
    );

    assign way_phys[w] = rd[N_ATTR +: PHYS_W];
    assign way_attr[w] = rd[N_ATTR-1:0];
  end

  // count qualifying ways and encode the (last) qualifying index
  logic [CNT_W-1:0]  hit_cnt;
  logic [WAY_W-1:0]  hit_idx;

  always_comb begin
    hit_cnt = '0;
    hit_idx = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) begin
        hit_cnt = hit_cnt + 1'b1;
        hit_idx = WAY_W'(w);
      end
    end
  end

  logic single_hit;
  assign single_hit = lk_fire && (hit_cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_phys  <= '0;
      rsp_way   <= '0;
      rsp_attr  <= '0;
    end else begin
      rsp_valid <= lk_fire;
      rsp_hit   <= single_hit;
      if (single_hit) begin
        rsp_phys <= way_phys[hit_idx];
        rsp_way  <= hit_idx;
        rsp_attr <= way_attr[hit_idx];
      end
    end
  end

endmodule

// File: rtl/tlb_testport_chk.sv
module tlb_testport_chk #(
  parameter int PHYS_W = 20,
  parameter int WAYS   = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic              op_lookup,
  input logic              dat_ctl,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [PHYS_W-1:0] rsp_phys,
  input logic [WAY_W-1:0]  rsp_way,
  input logic [2:0]        rsp_attr,
  input logic [WAY_W-1:0]  ptr
);

  p_rsp_follows_search_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_lookup) |=> rsp_valid);

  p_quiet_after_install_r11: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && op_lookup) |=> !rsp_valid);

  p_hit_qualified_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

  p_hold_on_miss_r9: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> ($stable(rsp_phys) && $stable(rsp_way) && $stable(rsp_attr)));

  p_ptr_advance_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_lookup && !dat_ctl) |=>
      (ptr == WAY_W'((int'($past(ptr)) + 1) % WAYS)));

  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && !op_lookup && !dat_ctl) |=> $stable(ptr));

endmodule

bind tlb_testport tlb_testport_chk #(.PHYS_W(PHYS_W), .WAYS(WAYS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .op_lookup (op_lookup),
  .dat_ctl   (dat_ctl),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_phys  (rsp_phys),
  .rsp_way   (rsp_way),
  .rsp_attr  (rsp_attr),
  .ptr       (ptr_q)
);

// File: tb/tb_tlb_testport.sv
`timescale 1ns/1ps
module tb_tlb_testport;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid, op_lookup, op_v, dat_ctl;
  logic [19:0] op_lin, dat_phys;
  logic [5:0]  op_attr;
  logic [1:0]  dat_way;
  logic        rsp_valid, rsp_hit;
  logic [19:0] rsp_phys;
  logic [1:0]  rsp_way;
  logic [2:0]  rsp_attr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tlb_testport dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_lookup(op_lookup),
    .op_lin(op_lin), .op_v(op_v), .op_attr(op_attr), .dat_phys(dat_phys),
    .dat_way(dat_way), .dat_ctl(dat_ctl), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_phys(rsp_phys), .rsp_way(rsp_way), .rsp_attr(rsp_attr)
  );

  typedef struct packed {
    logic        lk;
    logic [19:0] lin;
    logic        v;
    logic [5:0]  attr;   // {wr, user, dirty} selector pairs
    logic [19:0] phys;
    logic [1:0]  way;
    logic        ctl;
    logic        e_hit;
    logic [19:0] e_phys;
    logic [1:0]  e_way;
    logic [2:0]  e_attr; // {wr, user, dirty}
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{1'b0, 20'h00010, 1'b1, 6'b10_01_10, 20'hAAAAA, 2'd0, 1'b0, 1'b0, 20'h0,     2'd0, 3'b000},
    '{1'b1, 20'h00010, 1'b0, 6'b11_11_11, 20'h0,     2'd0, 1'b0, 1'b1, 20'hAAAAA, 2'd0, 3'b101},
    '{1'b0, 20'h00018, 1'b1, 6'b01_01_01, 20'h12345, 2'd0, 1'b0, 1'b0, 20'h0,     2'd0, 3'b000},
    '{1'b1, 20'h00018, 1'b0, 6'b11_11_11, 20'h0,     2'd0, 1'b0, 1'b1, 20'h12345, 2'd1, 3'b000},
    '{1'b1, 20'h00010, 1'b0, 6'b11_11_01, 20'h0,     2'd0, 1'b0, 1'b0, 20'h12345, 2'd1, 3'b000},
    '{1'b1, 20'h00010, 1'b0, 6'b11_00_11, 20'h0,     2'd0, 1'b0, 1'b0, 20'h12345, 2'd1, 3'b000},
    '{1'b0, 20'h00021, 1'b1, 6'b10_10_10, 20'h0F0F0, 2'd3, 1'b1, 1'b0, 20'h0,     2'd0, 3'b000},
    '{1'b1, 20'h00021, 1'b0, 6'b11_11_11, 20'h0,     2'd0, 1'b0, 1'b1, 20'h0F0F0, 2'd3, 3'b111},
    '{1'b0, 20'h00010, 1'b1, 6'b10_01_10, 20'h55555, 2'd0, 1'b0, 1'b0, 20'h0,     2'd0, 3'b000},
    '{1'b1, 20'h00010, 1'b0, 6'b11_11_11, 20'h0,     2'd0, 1'b0, 1'b0, 20'h0F0F0, 2'd3, 3'b111},
    '{1'b0, 20'h00010, 1'b0, 6'b11_11_11, 20'h0,     2'd0, 1'b1, 1'b0, 20'h0,     2'd0, 3'b000},
    '{1'b1, 20'h00010, 1'b0, 6'b11_11_11, 20'h0,     2'd0, 1'b0, 1'b1, 20'h55555, 2'd2, 3'b101},
    '{1'b0, 20'h00003, 1'b1, 6'b01_10_01, 20'h00777, 2'd0, 1'b0, 1'b0, 20'h0,     2'd0, 3'b000},
    '{1'b0, 20'h00004, 1'b1, 6'b10_10_10, 20'h00888, 2'd0, 1'b0, 1'b0, 20'h0,     2'd0, 3'b000},
    '{1'b1, 20'h00004, 1'b0, 6'b11_11_11, 20'h0,     2'd0, 1'b0, 1'b1, 20'h00888, 2'd0, 3'b111},
    '{1'b1, 20'h00003, 1'b0, 6'b01_10_01, 20'h0,     2'd0, 1'b0, 1'b1, 20'h00777, 2'd3, 3'b010},
    '{1'b1, 20'h0000B, 1'b0, 6'b11_11_11, 20'h0,     2'd0, 1'b0, 1'b0, 20'h00777, 2'd3, 3'b010}
  };

  // requirement exercised by each row
  string row_req [NV] = '{"R2", "R2", "R7", "R7", "R4", "R4", "R6", "R6", "R7",
                          "R9", "R10", "R10", "R7", "R7", "R7", "R5", "R3"};

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic lk, input logic [19:0] lin, input logic v,
                       input logic [5:0] attr, input logic [19:0] phys,
                       input logic [1:0] way, input logic ctl);
    op_valid = 1'b1; op_lookup = lk; op_lin = lin; op_v = v;
    op_attr = attr; dat_phys = phys; dat_way = way; dat_ctl = ctl;
  endtask

  task automatic idle();
    op_valid = 1'b0; op_lookup = 1'b0; op_lin = '0; op_v = 1'b0;
    op_attr = '0; dat_phys = '0; dat_way = '0; dat_ctl = 1'b0;
  endtask

  task automatic check_zero(input string req);
    chk(req, "rsp_valid", 32'(rsp_valid), 0);
    chk(req, "rsp_hit",   32'(rsp_hit),   0);
    chk(req, "rsp_phys",  32'(rsp_phys),  0);
    chk(req, "rsp_way",   32'(rsp_way),   0);
    chk(req, "rsp_attr",  32'(rsp_attr),  0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check_zero("R1");
    rst = 1'b0;
    @(negedge clk);
    check_zero("R1");

    // R1: nothing valid after reset
    drive(1'b1, 20'h00010, 1'b0, 6'b11_11_11, '0, '0, 1'b0);
    @(negedge clk);
    chk("R1", "rsp_valid after search", 32'(rsp_valid), 1);
    chk("R1", "rsp_hit after reset", 32'(rsp_hit), 0);

    // table, back to back
    for (int i = 0; i < NV; i++) begin
      drive(VT[i].lk, VT[i].lin, VT[i].v, VT[i].attr, VT[i].phys, VT[i].way, VT[i].ctl);
      @(negedge clk);
      if (VT[i].lk) begin
        chk(row_req[i], "rsp_valid", 32'(rsp_valid), 1);
        chk(row_req[i], "rsp_hit", 32'(rsp_hit), 32'(VT[i].e_hit));
        // R8 data on hit, R9 held data on miss
        chk(VT[i].e_hit ? "R8" : "R9", "rsp_phys", 32'(rsp_phys), 32'(VT[i].e_phys));
        chk(VT[i].e_hit ? "R8" : "R9", "rsp_way",  32'(rsp_way),  32'(VT[i].e_way));
        chk(VT[i].e_hit ? "R8" : "R9", "rsp_attr", 32'(rsp_attr), 32'(VT[i].e_attr));
      end else begin
        chk("R11", "rsp_valid after install", 32'(rsp_valid), 0);
        chk("R11", "rsp_hit after install", 32'(rsp_hit), 0);
      end
    end

    idle();
    @(negedge clk);
    chk("R11", "rsp_valid idle", 32'(rsp_valid), 0);

    // R1: reset clears entries and pointer
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_zero("R1");
    drive(1'b1, 20'h00004, 1'b0, 6'b11_11_11, '0, '0, 1'b0);
    @(negedge clk);
    chk("R1", "hit on cleared entry", 32'(rsp_hit), 0);
    drive(1'b0, 20'h00005, 1'b1, 6'b10_01_10, 20'h0ABCD, 2'd2, 1'b0);
    @(negedge clk);
    drive(1'b1, 20'h00005, 1'b0, 6'b10_01_10, '0, '0, 1'b0);
    @(negedge clk);
    chk("R1", "hit after pointer install", 32'(rsp_hit), 1);
    chk("R7", "pointer restarts at way 0", 32'(rsp_way), 0);
    chk("R8", "phys after reset install", 32'(rsp_phys), 32'h0ABCD);

    // R4: selector 00 accepts nothing
    drive(1'b1, 20'h00005, 1'b0, 6'b11_11_00, '0, '0, 1'b0);
    @(negedge clk);
    chk("R4", "code 00 never qualifies", 32'(rsp_hit), 0);
    idle();
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule